// File: doc/BRIEF.md
# Byte ALU with Registered Condition Flags

This block is the arithmetic and logic datapath of a small 8-bit processor core. A combinational unit takes one operation code and up to three byte operands: a first source, a second source and an immediate constant. It returns a one-byte result in the same cycle. Next to it sits a six-bit condition register holding the half-carry, sign, overflow, negative, zero and carry flags.

When the execute strobe is high, each flag that the current operation is allowed to touch is rewritten at the next rising clock edge. All other flags keep their value. Operations that take a carry read the carry bit from that register, so a multi-byte add or subtract runs as a chain of single-cycle steps.

The operations cover:
- add and subtract, with or without the stored carry, each with register and immediate forms;
- increment and decrement;
- two's complement and one's complement;
- bitwise AND, OR and XOR;
- single-bit shifts left and right, an arithmetic shift right, rotates through carry, and a swap of the two halves;
- a plain move.

Operand routing, register storage and control flow stay outside the block.

Top module: `alu8_flags`

## Requirements
- R1: After reset (rst_n low, asynchronous) all six flags read 0.
- R2: The flags port holds C at bit 0, Z at bit 1, N at bit 2, V at bit 3, S at bit 4 and H at bit 5. It changes only at a rising edge where exec_en is high; with exec_en low it stays stable.
- R3: ADD (0x01, src_a+src_b), ADDK (0x02, src_a+imm_k), ADC (0x03) and ADCK (0x04) add, and ADC/ADCK also add the stored C. They update all six flags: C is the carry out of bit 7, H the carry out of bit 3, V the signed overflow.
- R4: SUB (0x05, src_a-src_b), SUBK (0x06, src_a-imm_k), SBC (0x07) and SBCK (0x08) subtract, and SBC/SBCK also subtract the stored C. They update all six flags: C is the borrow out of bit 7, H the borrow out of bit 3, V the signed overflow.
- R5: INC (0x09) gives src_a+1 and DEC (0x0A) gives src_a-1. Both update S, V, N and Z only; C and H are kept. V is set for 0x7F incremented and for 0x80 decremented.
- R6: NEG (0x0B) gives 0-src_a and updates all six flags. C is set when src_a is nonzero, H when its low nibble is nonzero, and V when src_a is 0x80.
- R7: COM (0x0C) gives the bitwise inverse of src_a. It clears V, sets C, updates S, N and Z, and keeps H.
- R8: AND (0x0D), ANDK (0x0E), OR (0x0F), ORK (0x10), XOR (0x11) and XORK (0x12) combine src_a with src_b, or with imm_k in the K forms. They clear V, update S, N and Z, and keep C and H.
- R9: LSL (0x13) shifts src_a left with 0 entering bit 0. ROL (0x16) does the same with the old C entering bit 0. Both move old bit 7 into C and old bit 3 into H, and set V = N xor C.
- R10: LSR (0x14) shifts right with 0 entering bit 7, ASR (0x15) keeps bit 7, and ROR (0x17) puts the old C in bit 7. All three move old bit 0 into C, set V = N xor C, update S, N and Z, and keep H.
- R11: SWAP (0x18) exchanges the upper and lower nibbles of src_a, and PASS (0x00) outputs src_b. Neither changes any flag.
- R12: For every flag-writing operation, N is result bit 7, Z is set exactly when the result is zero, and S = N xor V holds at all times.
- R13: Any other code (0x19 to 0x1F) gives a zero result and changes no flag.
- R14: The carry consumed by ADC, SBC, ROL and ROR is the flag value written by the previous executed operation. An operation that reads C and also writes C uses the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | Commit this cycle's flag update |
| op_code | input | 5 | Operation select |
| src_a | input | DATA_W | First operand |
| src_b | input | DATA_W | Second operand (register form) |
| imm_k | input | DATA_W | Constant operand (K forms) |
| result | output | DATA_W | Combinational result |
| flags | output | 6 | Registered condition flags {H,S,V,N,Z,C} |

## Verification
Reading the stored carry and rewriting it fall in the same cycle whenever ADC, SBC, ROL or ROR executes. The bench provokes this in two ways: it chains two-byte additions and subtractions, and it issues rotates back to back with C preset to both values. It judges the combinational result against the carry held before the edge, and the flags sampled after the edge against the new carry. A second overlap, an INC or DEC that updates the sign flags while C must survive, is driven after an operation that left C set.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   localparam int NFLAG = 6;
   localparam int FC = 0;
   localparam int FZ = 1;
   localparam int FN = 2;
   localparam int FV = 3;
   localparam int FS = 4;
   localparam int FH = 5;

   localparam logic [4:0] OP_PASS = 5'h00;
   localparam logic [4:0] OP_ADD  = 5'h01;
   localparam logic [4:0] OP_ADDK = 5'h02;
   localparam logic [4:0] OP_ADC  = 5'h03;
   localparam logic [4:0] OP_ADCK = 5'h04;
   localparam logic [4:0] OP_SUB  = 5'h05;
   localparam logic [4:0] OP_SUBK = 5'h06;
   localparam logic [4:0] OP_SBC  = 5'h07;
   localparam logic [4:0] OP_SBCK = 5'h08;
   localparam logic [4:0] OP_INC  = 5'h09;
   localparam logic [4:0] OP_DEC  = 5'h0A;
   localparam logic [4:0] OP_NEG  = 5'h0B;
   localparam logic [4:0] OP_COM  = 5'h0C;
   localparam logic [4:0] OP_AND  = 5'h0D;
   localparam logic [4:0] OP_ANDK = 5'h0E;
   localparam logic [4:0] OP_OR   = 5'h0F;
   localparam logic [4:0] OP_ORK  = 5'h10;
   localparam logic [4:0] OP_XOR  = 5'h11;
   localparam logic [4:0] OP_XORK = 5'h12;
   localparam logic [4:0] OP_LSL  = 5'h13;
   localparam logic [4:0] OP_LSR  = 5'h14;
   localparam logic [4:0] OP_ASR  = 5'h15;
   localparam logic [4:0] OP_ROL  = 5'h16;
   localparam logic [4:0] OP_ROR  = 5'h17;
   localparam logic [4:0] OP_SWAP = 5'h18;

   typedef enum logic [1:0] {
      U_NONE  = 2'd0,
      U_ARITH = 2'd1,
      U_LOGIC = 2'd2,
      U_SHIFT = 2'd3
   } unit_e;

   typedef enum logic [1:0] {
      LG_AND = 2'd0,
      LG_OR  = 2'd1,
      LG_XOR = 2'd2,
      LG_INV = 2'd3
   } logic_sel_e;

   typedef enum logic [2:0] {
      SH_LSL  = 3'd0,
      SH_LSR  = 3'd1,
      SH_ASR  = 3'd2,
      SH_ROL  = 3'd3,
      SH_ROR  = 3'd4,
      SH_SWAP = 3'd5
   } shift_sel_e;

   localparam logic [NFLAG-1:0] M_ALL   = 6'b111111;
   localparam logic [NFLAG-1:0] M_SVNZC = 6'b011111;
   localparam logic [NFLAG-1:0] M_SVNZ  = 6'b011110;
   localparam logic [NFLAG-1:0] M_NONE  = 6'b000000;

   // Which flags an operation is permitted to rewrite.
   function automatic logic [NFLAG-1:0] flag_mask(input logic [4:0] op);
      case (op)
         OP_ADD, OP_ADDK, OP_ADC, OP_ADCK,
         OP_SUB, OP_SUBK, OP_SBC, OP_SBCK,
         OP_NEG, OP_LSL, OP_ROL:            flag_mask = M_ALL;
         OP_COM, OP_LSR, OP_ASR, OP_ROR:    flag_mask = M_SVNZC;
         OP_INC, OP_DEC,
         OP_AND, OP_ANDK, OP_OR, OP_ORK,
         OP_XOR, OP_XORK:                   flag_mask = M_SVNZ;
         default:                           flag_mask = M_NONE;
      endcase
   endfunction

   function automatic logic uses_imm(input logic [4:0] op);
      uses_imm = (op == OP_ADDK) || (op == OP_ADCK) || (op == OP_SUBK) ||
                 (op == OP_SBCK) || (op == OP_ANDK) || (op == OP_ORK)  ||
                 (op == OP_XORK);
   endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith #(
   parameter int DATA_W        = 8,
   parameter bit HALF_CARRY_EN = 1'b1
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              cin,
   input  logic              sub,
   output logic [DATA_W-1:0] sum,
   output logic              c_out,
   output logic              h_out,
   output logic              v_out
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W:0] full;

   always_comb begin
      if (sub) full = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, cin};
      else     full = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
   end

   assign sum   = full[MSB:0];
   assign c_out = full[DATA_W];

   // Signed overflow: operand signs agree (add) or differ (sub) and the
   // result sign departs from the first operand.
   assign v_out = sub ? ((a[MSB] ^ b[MSB]) & (sum[MSB] ^ a[MSB]))
                      : (~(a[MSB] ^ b[MSB]) & (sum[MSB] ^ a[MSB]));

   generate
      if (HALF_CARRY_EN) begin : g_half
         logic [4:0] nib;
         always_comb begin
            if (sub) nib = {1'b0, a[3:0]} - {1'b0, b[3:0]} - {4'b0, cin};
            else     nib = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'b0, cin};
         end
         assign h_out = nib[4];
      end else begin : g_nohalf
         assign h_out = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
   import alu8_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic_sel_e        sel,
   output logic [DATA_W-1:0] y
);
   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         assign y[i] = (sel == LG_AND) ? (a[i] & b[i]) :
                       (sel == LG_OR)  ? (a[i] | b[i]) :
                       (sel == LG_XOR) ? (a[i] ^ b[i]) :
                                         ~a[i];
      end
   endgenerate
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
   import alu8_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic              cin,
   input  shift_sel_e        sel,
   output logic [DATA_W-1:0] y,
   output logic              c_out,
   output logic              h_out
);
   localparam int MSB  = DATA_W - 1;
   localparam int HALF = DATA_W / 2;

   always_comb begin
      y     = a;
      c_out = 1'b0;
      case (sel)
         SH_LSL:  begin y = {a[MSB-1:0], 1'b0};   c_out = a[MSB]; end
         SH_ROL:  begin y = {a[MSB-1:0], cin};    c_out = a[MSB]; end
         SH_LSR:  begin y = {1'b0, a[MSB:1]};     c_out = a[0];   end
         SH_ASR:  begin y = {a[MSB], a[MSB:1]};   c_out = a[0];   end
         SH_ROR:  begin y = {cin, a[MSB:1]};      c_out = a[0];   end
         SH_SWAP: begin y = {a[HALF-1:0], a[MSB:HALF]}; end
         default: begin y = a; end
      endcase
   end

   // Left shifts double the operand, so bit 3 is the carry out of the low nibble.
   assign h_out = a[3];

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
   import alu8_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter bit HALF_CARRY_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exec_en,
   input  logic [4:0]        op_code,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [DATA_W-1:0] imm_k,
   output logic [DATA_W-1:0] result,
   output logic [NFLAG-1:0]  flags
);
   localparam int MSB = DATA_W - 1;
   localparam logic [NFLAG-1:0] H_KEEP = HALF_CARRY_EN ? M_ALL : ~(M_ALL & 6'b100000);

   generate
      if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("alu8_flags: DATA_W must be even and at least 4");
      end
   endgenerate

   logic [NFLAG-1:0]  flags_q;
   logic [DATA_W-1:0] opnd_b;
   unit_e             unit;

   logic [DATA_W-1:0] ar_a, ar_b, ar_sum;
   logic              ar_cin, ar_sub, ar_c, ar_h, ar_v;
   logic_sel_e        lg_sel;
   logic [DATA_W-1:0] lg_y;
   shift_sel_e        sh_sel;
   logic [DATA_W-1:0] sh_y;
   logic              sh_c, sh_h;

   logic [NFLAG-1:0]  nf;
   logic [NFLAG-1:0]  wmask;
   logic              f_n, f_z, f_v, f_c, f_h;

   assign opnd_b = uses_imm(op_code) ? imm_k : src_b;

   // Operand routing and unit selection
   always_comb begin
      unit   = U_NONE;
      ar_a   = src_a;
      ar_b   = opnd_b;
      ar_cin = 1'b0;
      ar_sub = 1'b0;
      lg_sel = LG_AND;
      sh_sel = SH_LSL;
      case (op_code)
         OP_ADD, OP_ADDK: unit = U_ARITH;
         OP_ADC, OP_ADCK: begin unit = U_ARITH; ar_cin = flags_q[FC]; end
         OP_SUB, OP_SUBK: begin unit = U_ARITH; ar_sub = 1'b1; end
         OP_SBC, OP_SBCK: begin unit = U_ARITH; ar_sub = 1'b1; ar_cin = flags_q[FC]; end
         OP_INC: begin unit = U_ARITH; ar_b = {{(DATA_W-1){1'b0}}, 1'b1}; end
         OP_DEC: begin unit = U_ARITH; ar_b = {{(DATA_W-1){1'b0}}, 1'b1}; ar_sub = 1'b1; end
         OP_NEG: begin unit = U_ARITH; ar_a = '0; ar_b = src_a; ar_sub = 1'b1; end
         OP_COM:          begin unit = U_LOGIC; lg_sel = LG_INV; end
         OP_AND, OP_ANDK: begin unit = U_LOGIC; lg_sel = LG_AND; end
         OP_OR,  OP_ORK:  begin unit = U_LOGIC; lg_sel = LG_OR;  end
         OP_XOR, OP_XORK: begin unit = U_LOGIC; lg_sel = LG_XOR; end
         OP_LSL:  begin unit = U_SHIFT; sh_sel = SH_LSL;  end
         OP_LSR:  begin unit = U_SHIFT; sh_sel = SH_LSR;  end
         OP_ASR:  begin unit = U_SHIFT; sh_sel = SH_ASR;  end
         OP_ROL:  begin unit = U_SHIFT; sh_sel = SH_ROL;  end
         OP_ROR:  begin unit = U_SHIFT; sh_sel = SH_ROR;  end
         OP_SWAP: begin unit = U_SHIFT; sh_sel = SH_SWAP; end
         default: unit = U_NONE;
      endcase
   end

   alu8_arith #(.DATA_W(DATA_W), .HALF_CARRY_EN(HALF_CARRY_EN)) u_arith (
      .a(ar_a), .b(ar_b), .cin(ar_cin), .sub(ar_sub),
      .sum(ar_sum), .c_out(ar_c), .h_out(ar_h), .v_out(ar_v)
   );

   alu8_logic #(.DATA_W(DATA_W)) u_logic (
      .a(src_a), .b(opnd_b), .sel(lg_sel), .y(lg_y)
   );

   alu8_shift #(.DATA_W(DATA_W)) u_shift (
      .a(src_a), .cin(flags_q[FC]), .sel(sh_sel),
      .y(sh_y), .c_out(sh_c), .h_out(sh_h)
   );

   // Result selection
   always_comb begin
      case (unit)
         U_ARITH: result = ar_sum;
         U_LOGIC: result = lg_y;
         U_SHIFT: result = sh_y;
         default: result = (op_code == OP_PASS) ? src_b : '0;
      endcase
   end

   // Candidate flags
   always_comb begin
      f_n = result[MSB];
      f_z = (result == '0);
      f_v = 1'b0;
      f_c = flags_q[FC];
      f_h = flags_q[FH];
      case (unit)
         U_ARITH: begin f_v = ar_v; f_c = ar_c; f_h = ar_h; end
         U_LOGIC: begin f_v = 1'b0; f_c = 1'b1; end
         U_SHIFT: begin f_v = f_n ^ sh_c; f_c = sh_c; f_h = HALF_CARRY_EN ? sh_h : 1'b0; end
         default: ;
      endcase
      nf        = '0;
      nf[FC]    = f_c;
      nf[FZ]    = f_z;
      nf[FN]    = f_n;
      nf[FV]    = f_v;
      nf[FS]    = f_n ^ f_v;
      nf[FH]    = f_h;
   end

   assign wmask = flag_mask(op_code) & H_KEEP;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flags_q <= '0;
      else if (exec_en) flags_q <= (flags_q & ~wmask) | (nf & wmask);
   end

   assign flags = flags_q;

   // ---------------- assertions ----------------
   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_en |=> $stable(flags));

   p_sign_rule_r12: assert property (@(posedge clk) disable iff (!rst_n)
      flags[FS] == (flags[FN] ^ flags[FV]));

   p_zero_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && op_code == OP_ADD) |=> flags[FZ] == ($past(result) == '0));

   p_incdec_keep_c_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && (op_code == OP_INC || op_code == OP_DEC))
      |=> (flags[FC] == $past(flags[FC])) && (flags[FH] == $past(flags[FH])));

   p_com_sets_c_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && op_code == OP_COM) |=> flags[FC] && !flags[FV]);

   p_logic_clear_v_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && op_code >= OP_AND && op_code <= OP_XORK)
      |=> !flags[FV] && $stable(flags[FC]));

   p_quiet_ops_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && (op_code == OP_PASS || op_code == OP_SWAP || op_code > OP_SWAP))
      |=> $stable(flags));

   p_rshift_carry_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && (op_code == OP_LSR || op_code == OP_ASR || op_code == OP_ROR))
      |=> flags[FC] == $past(src_a[0]));

endmodule

// File: tb/tb_alu8_flags.sv
module tb_alu8_flags;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       exec_en = 1'b0;
   logic [4:0] op_code = 5'h00;
   logic [7:0] src_a = 8'h00, src_b = 8'h00, imm_k = 8'h00;
   logic [7:0] result;
   logic [5:0] flags;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [5:0] exp_f = 6'h00;

   always #(CLK_P/2) clk = ~clk;

   alu8_flags dut (
      .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_code(op_code),
      .src_a(src_a), .src_b(src_b), .imm_k(imm_k),
      .result(result), .flags(flags)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // Reference model written from the requirement text.
   task automatic model(input logic [4:0] op, input logic [7:0] a, b, k,
                        input logic [5:0] fi, output logic [7:0] r, output logic [5:0] fo);
      logic [7:0] bv;
      logic [5:0] upd;
      logic c, h, v, n, cin;
      int sr, ur, hr;
      bv  = (op == 5'h02 || op == 5'h04 || op == 5'h06 || op == 5'h08 ||
             op == 5'h0E || op == 5'h10 || op == 5'h12) ? k : b;
      cin = (op == 5'h03 || op == 5'h04 || op == 5'h07 || op == 5'h08) ? fi[0] : 1'b0;
      c = fi[0]; h = fi[5]; v = 1'b0; upd = 6'h00; r = 8'h00;
      case (op)
         5'h01, 5'h02, 5'h03, 5'h04: begin
            ur = int'(a) + int'(bv) + int'(cin); r = ur[7:0];
            c = ur > 255; hr = int'(a[3:0]) + int'(bv[3:0]) + int'(cin); h = hr > 15;
            sr = int'($signed(a)) + int'($signed(bv)) + int'(cin); v = sr > 127 || sr < -128;
            upd = 6'h3F; end
         5'h05, 5'h06, 5'h07, 5'h08: begin
            ur = int'(a) - int'(bv) - int'(cin); r = ur[7:0];
            c = ur < 0; hr = int'(a[3:0]) - int'(bv[3:0]) - int'(cin); h = hr < 0;
            sr = int'($signed(a)) - int'($signed(bv)) - int'(cin); v = sr > 127 || sr < -128;
            upd = 6'h3F; end
         5'h09: begin r = a + 8'd1; v = (a == 8'h7F); upd = 6'h1E; end
         5'h0A: begin r = a - 8'd1; v = (a == 8'h80); upd = 6'h1E; end
         5'h0B: begin r = 8'd0 - a; c = (a != 0); h = (a[3:0] != 0); v = (a == 8'h80); upd = 6'h3F; end
         5'h0C: begin r = ~a; c = 1'b1; upd = 6'h1F; end
         5'h0D, 5'h0E: begin r = a & bv; upd = 6'h1E; end
         5'h0F, 5'h10: begin r = a | bv; upd = 6'h1E; end
         5'h11, 5'h12: begin r = a ^ bv; upd = 6'h1E; end
         5'h13: begin r = {a[6:0], 1'b0}; c = a[7]; h = a[3]; upd = 6'h3F; end
         5'h16: begin r = {a[6:0], fi[0]}; c = a[7]; h = a[3]; upd = 6'h3F; end
         5'h14: begin r = {1'b0, a[7:1]}; c = a[0]; upd = 6'h1F; end
         5'h15: begin r = {a[7], a[7:1]}; c = a[0]; upd = 6'h1F; end
         5'h17: begin r = {fi[0], a[7:1]}; c = a[0]; upd = 6'h1F; end
         5'h18: r = {a[3:0], a[7:4]};
         5'h00: r = b;
         default: r = 8'h00;
      endcase
      n = r[7];
      if (op >= 5'h13 && op <= 5'h17) v = n ^ c;
      for (int i = 0; i < 6; i++) begin
         if (upd[i]) begin
            case (i)
               0: fo[i] = c;
               1: fo[i] = (r == 8'h00);
               2: fo[i] = n;
               3: fo[i] = v;
               4: fo[i] = n ^ v;
               default: fo[i] = h;
            endcase
         end else fo[i] = fi[i];
      end
   endtask

   // Apply one operation; check the result before the edge, flags after it.
   task automatic do_op(input string tag, input logic [4:0] op,
                        input logic [7:0] a, b, k, input logic en);
      logic [7:0] er;
      logic [5:0] ef;
      @(negedge clk);
      op_code = op; src_a = a; src_b = b; imm_k = k; exec_en = en;
      model(op, a, b, k, exp_f, er, ef);
      #1;
      chk({tag, " result"}, result, er);
      @(posedge clk);
      @(negedge clk);
      exec_en = 1'b0;
      if (en) exp_f = ef;
      chk({tag, " flags"}, {2'b00, flags}, {2'b00, exp_f});
   endtask

   task automatic t_reset;
      chk("R1 reset flags", {2'b00, flags}, 8'h00);
      do_op("R11 pass after reset", 5'h00, 8'h00, 8'h5A, 8'h00, 1'b1);
   endtask

   task automatic t_add;
      do_op("R3 add plain", 5'h01, 8'h12, 8'h34, 8'h00, 1'b1);
      do_op("R3 add carry-out zero", 5'h01, 8'hFF, 8'h01, 8'h00, 1'b1);
      do_op("R3 add signed overflow", 5'h01, 8'h7F, 8'h01, 8'h00, 1'b1);
      do_op("R3 add imm half carry", 5'h02, 8'h0F, 8'hEE, 8'h01, 1'b1);
      do_op("R3 adc with C=0", 5'h03, 8'h10, 8'h20, 8'h00, 1'b1);
      do_op("R3 set C", 5'h01, 8'h80, 8'h80, 8'h00, 1'b1);
      do_op("R3 adck with C=1", 5'h04, 8'h01, 8'h00, 8'hFE, 1'b1);
   endtask

   task automatic t_sub;
      do_op("R4 sub equal", 5'h05, 8'h42, 8'h42, 8'h00, 1'b1);
      do_op("R4 sub borrow", 5'h05, 8'h10, 8'h20, 8'h00, 1'b1);
      do_op("R4 sbc with C=1", 5'h07, 8'h50, 8'h10, 8'h00, 1'b1);
      do_op("R4 subk overflow", 5'h06, 8'h80, 8'h00, 8'h01, 1'b1);
      do_op("R4 sbck half borrow", 5'h08, 8'h31, 8'h00, 8'h02, 1'b1);
   endtask

   task automatic t_incdec;
      do_op("R5 set C first", 5'h05, 8'h00, 8'h01, 8'h00, 1'b1);
      do_op("R5 inc 7F", 5'h09, 8'h7F, 8'h00, 8'h00, 1'b1);
      do_op("R5 inc FF keeps C", 5'h09, 8'hFF, 8'h00, 8'h00, 1'b1);
      do_op("R5 dec 80", 5'h0A, 8'h80, 8'h00, 8'h00, 1'b1);
      do_op("R5 dec 01", 5'h0A, 8'h01, 8'h00, 8'h00, 1'b1);
   endtask

   task automatic t_neg_com;
      do_op("R6 neg 00", 5'h0B, 8'h00, 8'h00, 8'h00, 1'b1);
      do_op("R6 neg 80", 5'h0B, 8'h80, 8'h00, 8'h00, 1'b1);
      do_op("R6 neg 01", 5'h0B, 8'h01, 8'h00, 8'h00, 1'b1);
      do_op("R7 com 00", 5'h0C, 8'h00, 8'h00, 8'h00, 1'b1);
      do_op("R7 com FF", 5'h0C, 8'hFF, 8'h00, 8'h00, 1'b1);
   endtask

   task automatic t_logic;
      do_op("R8 overflow first", 5'h01, 8'h7F, 8'h7F, 8'h00, 1'b1);
      do_op("R8 and", 5'h0D, 8'hF0, 8'h3C, 8'h00, 1'b1);
      do_op("R8 andk zero", 5'h0E, 8'hF0, 8'hFF, 8'h0F, 1'b1);
      do_op("R8 or", 5'h0F, 8'h81, 8'h02, 8'h00, 1'b1);
      do_op("R8 ork", 5'h10, 8'h01, 8'h00, 8'h10, 1'b1);
      do_op("R8 xor", 5'h11, 8'hAA, 8'hAA, 8'h00, 1'b1);
      do_op("R8 xork", 5'h12, 8'hAA, 8'h00, 8'h55, 1'b1);
   endtask

   task automatic t_shifts;
      do_op("R9 lsl", 5'h13, 8'h88, 8'h00, 8'h00, 1'b1);
      do_op("R9 rol C=1", 5'h16, 8'h40, 8'h00, 8'h00, 1'b1);
      do_op("R9 rol C=0", 5'h16, 8'h01, 8'h00, 8'h00, 1'b1);
      do_op("R10 lsr", 5'h14, 8'h81, 8'h00, 8'h00, 1'b1);
      do_op("R10 ror C=1", 5'h17, 8'h02, 8'h00, 8'h00, 1'b1);
      do_op("R10 asr", 5'h15, 8'h81, 8'h00, 8'h00, 1'b1);
      do_op("R10 ror C=1 again", 5'h17, 8'h00, 8'h00, 8'h00, 1'b1);
   endtask

   task automatic t_quiet;
      do_op("R11 swap", 5'h18, 8'h3C, 8'h00, 8'h00, 1'b1);
      do_op("R11 pass", 5'h00, 8'h00, 8'h00, 8'h00, 1'b1);
      do_op("R13 undefined 19", 5'h19, 8'hFF, 8'hFF, 8'hFF, 1'b1);
      do_op("R13 undefined 1F", 5'h1F, 8'h12, 8'h34, 8'h56, 1'b1);
      do_op("R2 idle add", 5'h01, 8'h00, 8'h00, 8'h00, 1'b0);
      do_op("R2 idle com", 5'h0C, 8'h55, 8'h00, 8'h00, 1'b0);
   endtask

   task automatic t_chain;
      // 0x12FF + 0x0001 as two bytes, then 0x1000 - 0x0001
      do_op("R14 add low", 5'h01, 8'hFF, 8'h01, 8'h00, 1'b1);
      chk("R14 low carry set", {7'b0, flags[0]}, 8'h01);
      do_op("R14 adc high", 5'h03, 8'h12, 8'h00, 8'h00, 1'b1);
      do_op("R14 sub low", 5'h05, 8'h00, 8'h01, 8'h00, 1'b1);
      do_op("R14 sbc high", 5'h07, 8'h10, 8'h00, 8'h00, 1'b1);
      chk("R14 chain carry clear", {7'b0, flags[0]}, 8'h00);
      do_op("R12 zero and sign", 5'h05, 8'h01, 8'h02, 8'h00, 1'b1);
   endtask

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual running expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_add();
      t_sub();
      t_incdec();
      t_neg_com();
      t_logic();
      t_shifts();
      t_quiet();
      t_chain();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule